// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers every interrupt request a small CPU core can see and hands the core one vector number at a time. The sources are a non-maskable input, eight active-low external request lines, a parameterized group of internal peripheral requests, and a watchdog request. One of the external lines, line 6, is not a plain pin. It merges eight active-low key inputs, and each key input has its own enable bit.

External pins and the non-maskable pin each pass through a two-flop synchronizer before edge detection. Each external line can detect either a falling edge or a low level. The non-maskable input is always edge-detected, and a control bit chooses the rising or the falling edge. The watchdog request can be routed to the non-maskable path or to a maskable source of its own.

The core pulses an instruction-boundary strobe between two instructions. Acceptance is decided only at that strobe, so the controller picks the highest-priority eligible request there. It then presents that vector until the core acknowledges it. Acceptance is held off in two cases:
- at the first boundary after reset, so the core can set up its stack pointer;
- at any boundary where the instruction just completed wrote the condition register.

Top module: `vic_top`

## Requirements
- R1: A pending non-maskable request is accepted at an allowed boundary with vector 0, whatever the global mask bit, ahead of every other source.
- R2: While `cpu_imask` is 1 at a boundary, no source other than the non-maskable one is accepted.
- R3: External line i uses falling-edge sensing when `irq_lvl[i]` is 0, and the request then stays pending until acknowledged. It uses low-level sensing when `irq_lvl[i]` is 1, and the request is then pending only while the synchronized line is low.
- R4: The non-maskable input is edge-detected: rising edge when `nmi_rise` is 1, falling edge when it is 0.
- R5: Line 6 reads low whenever `irq_n[6]` is low or any key input `key_n[k]` is low with `key_en[k]` = 1. Key inputs with `key_en[k]` = 0 have no effect.
- R6: Vector numbers are 0 for the non-maskable source, 1+i for external line i, 9+j for internal request j, and 9+N_INT for the maskable watchdog (13 by default).
- R7: When several eligible requests are pending, the lowest vector number is presented.
- R8: The first boundary strobe after reset accepts nothing, including a pending non-maskable request.
- R9: Acceptance happens only on a boundary strobe, and never on a boundary where `cpu_ccr_write` is 1; the next boundary without it may accept.
- R10: A `wdt_req` pulse sets the non-maskable request when `wdt_to_nmi` is 1, and otherwise sets the maskable watchdog request.
- R11: An accepted vector keeps `irq_valid` high and `irq_vector` stable until `cpu_ack`, and `irq_valid` falls on the clock after the acknowledge.
- R12: An acknowledge clears the edge-sensed pending flag of the presented vector, but a new edge on that source in the same clock leaves it pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_in | input | 1 | Non-maskable request pin, asynchronous |
| nmi_rise | input | 1 | 1: rising edge, 0: falling edge on nmi_in |
| irq_n | input | 8 | Active-low external request lines, asynchronous |
| irq_lvl | input | 8 | Per-line sense: 0 falling edge, 1 low level |
| key_n | input | 8 | Active-low key inputs merged onto line 6 |
| key_en | input | 8 | Per-key enable, 1 lets the key drive line 6 |
| int_req | input | N_INT | Active-high internal requests, synchronous level |
| wdt_req | input | 1 | Watchdog request pulse, synchronous |
| wdt_to_nmi | input | 1 | 1 routes the watchdog to the non-maskable path |
| cpu_imask | input | 1 | Global mask bit from the core |
| cpu_boundary | input | 1 | One-cycle strobe at an instruction boundary |
| cpu_ccr_write | input | 1 | With the strobe: the finished instruction wrote the condition register |
| cpu_ack | input | 1 | Core takes the presented vector |
| irq_valid | output | 1 | A vector is presented |
| irq_vector | output | VW | Presented vector number |

## Verification
Two things can happen in the same clock: the core acknowledges the non-maskable vector, and a fresh edge on the non-maskable pin reaches its pending flag. The bench drives the pin change at the exact negedge that makes the synchronized edge land on the acknowledge clock. It then expects `irq_valid` to drop while the request stays pending, and the next allowed boundary to present vector 0 again. The bench also tests a boundary that carries a condition-register write while a non-maskable request waits. Here the hold-off must win over the highest-priority source.

// File: rtl/vic_pkg.sv
// Package vic_pkg: shared types for the interrupt controller.
// Assumes: sense-mode bits arrive as plain logic and are cast to sense_e.
package vic_pkg;
    // Sense mode of one external line
    typedef enum logic {
        SENSE_FALL = 1'b0,
        SENSE_LOW  = 1'b1
    } sense_e;

    // Index of the external line fed by the key group
    localparam int KEY_LINE = 6;
endpackage

// File: rtl/vic_sync.sv
// Module vic_sync: two-flop synchronizer for a vector of asynchronous pins.
// Assumes: each bit is independent; pins idle at RST_VAL during reset.
module vic_sync #(
    parameter int  W       = 9,
    parameter bit  RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    // Two-stage capture of the asynchronous inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= {W{RST_VAL}};
            stab_q <= {W{RST_VAL}};
        end else begin
            meta_q <= async_in;
            stab_q <= meta_q;
        end
    end

    assign sync_out = stab_q;
endmodule

// File: rtl/vic_sense.sv
// Module vic_sense: per-line falling-edge or low-level request detection.
// Assumes: line_n is already synchronized; a new edge beats a clear in the same cycle.
module vic_sense
    import vic_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] line_n,
    input  logic [N-1:0] lvl_mode,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    logic [N-1:0] prev_q;
    logic [N-1:0] edge_q;

    // Previous synchronized value, used for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= line_n;
    end

    for (genvar g = 0; g < N; g++) begin : g_line
        // Sticky falling-edge flag; held clear while the line is level-sensed
        always_ff @(posedge clk) begin
            if (!rst_n)
                edge_q[g] <= 1'b0;
            else if (sense_e'(lvl_mode[g]) == SENSE_LOW)
                edge_q[g] <= 1'b0;
            else if (prev_q[g] && !line_n[g])
                edge_q[g] <= 1'b1;
            else if (clr[g])
                edge_q[g] <= 1'b0;
        end

        // Pending view: level follows the line, edge follows the flag
        assign pend[g] = (sense_e'(lvl_mode[g]) == SENSE_LOW) ? !line_n[g] : edge_q[g];
    end
endmodule

// File: rtl/vic_arbiter.sv
// Module vic_arbiter: fixed-priority pick, the lowest index wins.
// Assumes: requests are already masked; purely combinational.
module vic_arbiter #(
    parameter int NSRC = 14,
    parameter int VW   = 4
) (
    input  logic [NSRC-1:0] req,
    output logic            hit,
    output logic [VW-1:0]   vec
);
    // Scan from the lowest priority up so that the lowest index is kept
    always_comb begin
        hit = |req;
        vec = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) vec = VW'(i);
        end
    end
endmodule

// File: rtl/vic_top.sv
// Module vic_top: prioritized vectored interrupt controller.
// Collects the non-maskable, external, key-group, internal and watchdog
// requests, and presents one vector per acceptance at an instruction boundary.
// Assumes: nmi_in and irq_n sit at their idle high level during reset;
// int_req and wdt_req are synchronous to clk.
module vic_top
    import vic_pkg::*;
#(
    parameter int N_EXT = 8,
    parameter int N_KEY = 8,
    parameter int N_INT = 4,
    localparam int NSRC   = 1 + N_EXT + N_INT + 1,
    localparam int VW     = $clog2(NSRC),
    localparam int V_EXT0 = 1,
    localparam int V_INT0 = 1 + N_EXT,
    localparam int V_WDT  = NSRC - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_in,
    input  logic             nmi_rise,
    input  logic [N_EXT-1:0] irq_n,
    input  logic [N_EXT-1:0] irq_lvl,
    input  logic [N_KEY-1:0] key_n,
    input  logic [N_KEY-1:0] key_en,
    input  logic [N_INT-1:0] int_req,
    input  logic             wdt_req,
    input  logic             wdt_to_nmi,
    input  logic             cpu_imask,
    input  logic             cpu_boundary,
    input  logic             cpu_ccr_write,
    input  logic             cpu_ack,
    output logic             irq_valid,
    output logic [VW-1:0]    irq_vector
);
    logic             key_hit;
    logic [N_EXT-1:0] line_raw;
    logic [N_EXT-1:0] line_sync;
    logic             nmi_sync;
    logic             nmi_prev_q;
    logic             nmi_edge;
    logic             nmi_pend_q;
    logic             wdt_pend_q;
    logic             inhibit_q;
    logic             valid_q;
    logic [VW-1:0]    vec_q;
    logic             ack_fire;
    logic             accept_ok;
    logic [N_EXT-1:0] ext_clr;
    logic [N_EXT-1:0] ext_pend;
    logic [NSRC-1:0]  req_vec;
    logic             arb_hit;
    logic [VW-1:0]    arb_vec;

    // Merge enabled, low key inputs onto the key line
    always_comb begin
        key_hit  = |(~key_n & key_en);
        line_raw = irq_n;
        line_raw[KEY_LINE] = irq_n[KEY_LINE] & ~key_hit;
    end

    vic_sync #(
        .W       (N_EXT + 1),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({nmi_in, line_raw}),
        .sync_out ({nmi_sync, line_sync})
    );

    assign ack_fire = valid_q && cpu_ack;

    for (genvar g = 0; g < N_EXT; g++) begin : g_clr
        assign ext_clr[g] = ack_fire && (vec_q == VW'(V_EXT0 + g));
    end

    vic_sense #(
        .N (N_EXT)
    ) u_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_n   (line_sync),
        .lvl_mode (irq_lvl),
        .clr      (ext_clr),
        .pend     (ext_pend)
    );

    // Previous synchronized non-maskable level
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_prev_q <= 1'b1;
        else        nmi_prev_q <= nmi_sync;
    end

    assign nmi_edge = nmi_rise ? (!nmi_prev_q && nmi_sync) : (nmi_prev_q && !nmi_sync);

    // Non-maskable pending flag: set by an edge or the routed watchdog, set wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            nmi_pend_q <= 1'b0;
        else if (nmi_edge || (wdt_req && wdt_to_nmi))
            nmi_pend_q <= 1'b1;
        else if (ack_fire && vec_q == '0)
            nmi_pend_q <= 1'b0;
    end

    // Maskable watchdog pending flag
    always_ff @(posedge clk) begin
        if (!rst_n)
            wdt_pend_q <= 1'b0;
        else if (wdt_req && !wdt_to_nmi)
            wdt_pend_q <= 1'b1;
        else if (ack_fire && vec_q == VW'(V_WDT))
            wdt_pend_q <= 1'b0;
    end

    // Eligible requests in vector order, the mask applied to all but vector 0
    always_comb begin
        req_vec                          = '0;
        req_vec[0]                       = nmi_pend_q;
        req_vec[V_EXT0 +: N_EXT]         = ext_pend & {N_EXT{!cpu_imask}};
        req_vec[V_INT0 +: N_INT]         = int_req & {N_INT{!cpu_imask}};
        req_vec[V_WDT]                   = wdt_pend_q && !cpu_imask;
    end

    vic_arbiter #(
        .NSRC (NSRC),
        .VW   (VW)
    ) u_arb (
        .req (req_vec),
        .hit (arb_hit),
        .vec (arb_vec)
    );

    // Reset hold-off, released by the first boundary
    always_ff @(posedge clk) begin
        if (!rst_n)            inhibit_q <= 1'b1;
        else if (cpu_boundary) inhibit_q <= 1'b0;
    end

    assign accept_ok = cpu_boundary && !inhibit_q && !cpu_ccr_write && !valid_q;

    // Presented vector: captured at an allowed boundary, held until acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            vec_q   <= '0;
        end else if (ack_fire) begin
            valid_q <= 1'b0;
        end else if (accept_ok && arb_hit) begin
            valid_q <= 1'b1;
            vec_q   <= arb_vec;
        end
    end

    assign irq_valid  = valid_q;
    assign irq_vector = vec_q;
endmodule

// File: rtl/vic_checker.sv
// Module vic_checker: temporal checks on the interrupt controller, bound to vic_top.
// Assumes: inhibit and the non-maskable pending flag are reachable in the bound scope.
module vic_checker #(
    parameter int VW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_imask,
    input logic          cpu_boundary,
    input logic          cpu_ccr_write,
    input logic          cpu_ack,
    input logic          irq_valid,
    input logic [VW-1:0] irq_vector,
    input logic          inhibit_q,
    input logic          nmi_pend
);
    // A waiting non-maskable request wins an allowed boundary
    assert_nmi_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_boundary && !cpu_ccr_write && !inhibit_q && !irq_valid && nmi_pend)
        |=> (irq_valid && irq_vector == '0));

    // A maskable vector appears only if the mask was clear when it was taken
    assert_mask_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_valid) && irq_vector != '0) |-> !$past(cpu_imask));

    // Nothing is taken while the reset hold-off is active
    assert_reset_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_valid) |-> !$past(inhibit_q));

    // Acceptance only on a boundary without a condition-register write
    assert_ccr_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_valid) |-> ($past(cpu_boundary) && !$past(cpu_ccr_write)));

    // The presented vector stays put until acknowledged
    assert_hold_vector_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !cpu_ack) |=> (irq_valid && $stable(irq_vector)));

    // An acknowledge releases the presentation on the next clock
    assert_ack_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && cpu_ack) |=> !irq_valid);
endmodule

bind vic_top vic_checker #(
    .VW (VW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_imask     (cpu_imask),
    .cpu_boundary  (cpu_boundary),
    .cpu_ccr_write (cpu_ccr_write),
    .cpu_ack       (cpu_ack),
    .irq_valid     (irq_valid),
    .irq_vector    (irq_vector),
    .inhibit_q     (inhibit_q),
    .nmi_pend      (nmi_pend_q)
);

// File: tb/vic_top_tb.sv
// Bench vic_top_tb: seeded random stimulus plus directed corners, checked
// against a transaction-level model of pending requests kept in the bench.
module vic_top_tb;
    localparam int N_INT = 4;
    localparam int VW    = 4;
    localparam int V_WDT = 9 + N_INT;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             nmi_in = 1'b1;
    logic             nmi_rise = 1'b0;
    logic [7:0]       irq_n = 8'hFF;
    logic [7:0]       irq_lvl = 8'h00;
    logic [7:0]       key_n = 8'hFF;
    logic [7:0]       key_en = 8'h00;
    logic [N_INT-1:0] int_req = '0;
    logic             wdt_req = 1'b0;
    logic             wdt_to_nmi = 1'b0;
    logic             cpu_imask = 1'b0;
    logic             cpu_boundary = 1'b0;
    logic             cpu_ccr_write = 1'b0;
    logic             cpu_ack = 1'b0;
    logic             irq_valid;
    logic [VW-1:0]    irq_vector;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    // Model state
    bit       m_nmi_p = 1'b0;
    bit       m_wdt_p = 1'b0;
    bit       m_inh   = 1'b1;
    bit [7:0] m_edge  = 8'h00;

    always #4 clk = ~clk;

    vic_top #(
        .N_EXT (8),
        .N_KEY (8),
        .N_INT (N_INT)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .nmi_in        (nmi_in),
        .nmi_rise      (nmi_rise),
        .irq_n         (irq_n),
        .irq_lvl       (irq_lvl),
        .key_n         (key_n),
        .key_en        (key_en),
        .int_req       (int_req),
        .wdt_req       (wdt_req),
        .wdt_to_nmi    (wdt_to_nmi),
        .cpu_imask     (cpu_imask),
        .cpu_boundary  (cpu_boundary),
        .cpu_ccr_write (cpu_ccr_write),
        .cpu_ack       (cpu_ack),
        .irq_valid     (irq_valid),
        .irq_vector    (irq_vector)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Effective line levels after the key merge (R5)
    function automatic logic [7:0] eff(input logic [7:0] ir, input logic [7:0] kn,
                                       input logic [7:0] ke);
        logic [7:0] r;
        r = ir;
        if (|(~kn & ke)) r[6] = 1'b0;
        return r;
    endfunction

    // Expected pick by fixed priority and numbering (R6, R7, R1, R2)
    function automatic int pick(input logic imask);
        logic [7:0] e;
        e = eff(irq_n, key_n, key_en);
        if (m_nmi_p) return 0;
        if (imask) return -1;
        for (int i = 0; i < 8; i++)
            if (m_edge[i] || (irq_lvl[i] && !e[i])) return 1 + i;
        for (int j = 0; j < N_INT; j++)
            if (int_req[j]) return 9 + j;
        if (m_wdt_p) return V_WDT;
        return -1;
    endfunction

    task automatic m_clear(input int v);
        if (v == 0) m_nmi_p = 1'b0;
        else if (v >= 1 && v <= 8) m_edge[v-1] = 1'b0;
        else if (v == V_WDT) m_wdt_p = 1'b0;
    endtask

    // Drive pins and sense settings, update the model's sticky flags (R3, R4, R5)
    task automatic apply(input logic n_nmi, input logic [7:0] n_irq, input logic [7:0] n_key,
                         input logic [7:0] n_ken, input logic [7:0] n_lvl, input logic n_rise);
        logic [7:0] oe;
        logic [7:0] ne;
        oe = eff(irq_n, key_n, key_en);
        ne = eff(n_irq, n_key, n_ken);
        for (int i = 0; i < 8; i++) begin
            if (n_lvl[i]) m_edge[i] = 1'b0;
            else if (oe[i] && !ne[i]) m_edge[i] = 1'b1;
        end
        if (n_rise ? (!nmi_in && n_nmi) : (nmi_in && !n_nmi)) m_nmi_p = 1'b1;
        @(negedge clk);
        nmi_in = n_nmi; irq_n = n_irq; key_n = n_key; key_en = n_ken;
        irq_lvl = n_lvl; nmi_rise = n_rise;
        repeat (6) @(negedge clk);
    endtask

    task automatic wdt_pulse(input logic to_nmi);
        @(negedge clk);
        wdt_to_nmi = to_nmi; wdt_req = 1'b1;
        @(negedge clk);
        wdt_req = 1'b0;
        if (to_nmi) m_nmi_p = 1'b1; else m_wdt_p = 1'b1;
        @(negedge clk);
    endtask

    // One boundary strobe, then check acceptance, hold and optional acknowledge
    task automatic boundary(input string tag, input logic imask, input logic ccr,
                            input bit do_ack);
        int  v;
        bit  exp_v;
        logic [VW-1:0] seen;
        v = pick(imask);
        exp_v = !m_inh && !ccr && (v >= 0);
        m_inh = 1'b0;
        @(negedge clk);
        cpu_imask = imask; cpu_boundary = 1'b1; cpu_ccr_write = ccr;
        @(negedge clk);
        cpu_boundary = 1'b0; cpu_ccr_write = 1'b0;
        check({tag, " valid"}, int'(irq_valid), int'(exp_v));
        if (exp_v && irq_valid) check({tag, " vector"}, int'(irq_vector), v);
        if (irq_valid && do_ack) begin
            seen = irq_vector;
            repeat (3) @(negedge clk);
            check("R11 hold", int'(irq_valid && irq_vector == seen), 1);
            cpu_ack = 1'b1;
            @(negedge clk);
            cpu_ack = 1'b0;
            check("R11 release", int'(irq_valid), 0);
            m_clear(int'(seen));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'h5EED1234));
        repeat (4) @(negedge clk);
        check("R11 reset valid", int'(irq_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 / R9 / R1: hold-offs then a non-maskable acceptance
        apply(1'b0, irq_n, key_n, key_en, irq_lvl, 1'b0);
        boundary("R8 first boundary", 1'b1, 1'b0, 1'b1);
        boundary("R9 ccr write", 1'b1, 1'b1, 1'b1);
        boundary("R1 nmi under mask", 1'b1, 1'b0, 1'b1);

        // R12: new falling edge lands on the acknowledge clock
        apply(1'b1, irq_n, key_n, key_en, irq_lvl, 1'b0);
        wdt_pulse(1'b1);
        boundary("R10 wdt to nmi", 1'b0, 1'b0, 1'b0);
        check("R10 vector0", int'(irq_vector), 0);
        @(negedge clk);
        nmi_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        cpu_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0;
        check("R12 collision release", int'(irq_valid), 0);
        repeat (4) @(negedge clk);
        boundary("R12 edge survives ack", 1'b0, 1'b0, 1'b1);

        // R4: rising edge selected
        apply(1'b0, irq_n, key_n, key_en, irq_lvl, 1'b1);
        boundary("R4 no fall in rise mode", 1'b0, 1'b0, 1'b1);
        apply(1'b1, irq_n, key_n, key_en, irq_lvl, 1'b1);
        boundary("R4 rise", 1'b0, 1'b0, 1'b1);

        // R2 / R7 / R3: level line and internal request under mask, then released
        apply(1'b1, 8'hFB, key_n, key_en, 8'h04, 1'b1);
        @(negedge clk); int_req = 4'b0010;
        boundary("R2 masked", 1'b1, 1'b0, 1'b1);
        boundary("R7 line2 over internal", 1'b0, 1'b0, 1'b1);
        boundary("R3 level still low", 1'b0, 1'b0, 1'b1);
        apply(1'b1, 8'hFF, key_n, key_en, 8'h04, 1'b1);
        boundary("R6 internal vector", 1'b0, 1'b0, 1'b1);
        @(negedge clk); int_req = '0;

        // R5: disabled key ignored, enabled key raises line 6
        apply(1'b1, 8'hFF, 8'hDF, 8'h00, 8'h00, 1'b1);
        boundary("R5 key disabled", 1'b0, 1'b0, 1'b1);
        apply(1'b1, 8'hFF, 8'hDF, 8'h20, 8'h00, 1'b1);
        boundary("R5 key enabled", 1'b0, 1'b0, 1'b1);
        apply(1'b1, 8'hFF, 8'hFF, 8'h20, 8'h00, 1'b1);

        // R10: maskable watchdog
        wdt_pulse(1'b0);
        boundary("R10 wdt maskable masked", 1'b1, 1'b0, 1'b1);
        boundary("R10 wdt maskable", 1'b0, 1'b0, 1'b1);

        // Seeded random mix over all sources (R3, R5, R6, R7, R9)
        for (int t = 0; t < 300; t++) begin
            r = $urandom;
            case (r[2:0])
                3'd0, 3'd1, 3'd2:
                    apply(r[3] ? ~nmi_in : nmi_in,
                          irq_n ^ (8'($urandom) & 8'($urandom) & 8'($urandom)),
                          key_n ^ (8'($urandom) & 8'($urandom) & 8'($urandom)),
                          key_en, irq_lvl, nmi_rise);
                3'd3:
                    apply(nmi_in, irq_n, key_n, 8'($urandom), 8'($urandom), r[4]);
                3'd4:
                    wdt_pulse(r[5]);
                3'd5: begin
                    @(negedge clk);
                    int_req = N_INT'($urandom) & N_INT'($urandom);
                    @(negedge clk);
                end
                default:
                    apply(nmi_in, 8'hFF, 8'hFF, key_en, irq_lvl, nmi_rise);
            endcase
            boundary("R7 random", (r[9:8] == 2'd0), (r[12:10] == 3'd0), 1'b1);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule